// File: doc/BRIEF.md
# Width-Adapting Memory Bus Handshake Controller

This block connects a CPU-side word register interface to a main-memory port whose data bus may be narrower than the CPU word. The CPU presents an address, a write word, a direction bit and a one-cycle start strobe. The block then runs one memory beat for each bus-width slice of the word. Each beat carries its own address, which is the base address plus the beat number counted in bus-width units. The CPU receives a single done pulse when the whole word has been moved. On a read, the fully assembled word appears in the CPU data register in that same cycle.

Each beat runs a four-phase handshake. The request stays high until the memory raises its completion line. The request then drops, and the next beat waits until the completion line has fallen. A fixed-latency mode is selected per access. In that mode the completion line is ignored, and each beat holds the request for a parameter-set number of cycles. Another per-access input picks the slice order. In little-endian order the least significant slice goes to the lowest address. In big-endian order the most significant slice goes there.

Top module: `membus_adapter`

## Requirements
- R1: While reset is held and just after it, `mem_req`, `cpu_busy` and `cpu_done` are 0 and `cpu_rdata` is all zeros.
- R2: An accepted access produces exactly WORD_W/BEAT_W request pulses. Pulse k (k = 0 first) carries `mem_addr` = base + k.
- R3: With `big_endian` = 0, beat k moves word bits [k*BEAT_W +: BEAT_W]. For example, writing 32'h11223344 at base A stores 8'h44 at A and 8'h11 at A+3.
- R4: With `big_endian` = 1, beat k moves word bits [(N-1-k)*BEAT_W +: BEAT_W], where N = WORD_W/BEAT_W. The same word at base A stores 8'h11 at A. Reading it back little-endian gives 32'h44332211.
- R5: In handshake mode (`fixed_mode` = 0), `mem_req` stays high while `mem_complete` is low. It is low in the cycle after `mem_complete` is seen high. It does not rise for the next beat until `mem_complete` has returned low.
- R6: While `mem_req` stays high, `mem_addr`, `mem_wdata` and `mem_rw` (1 = write) do not change.
- R7: In fixed mode (`fixed_mode` = 1 at start), every request pulse lasts exactly WAIT_CYCLES cycles whatever `mem_complete` does.
- R8: `cpu_done` is a one-cycle pulse after the last beat. `cpu_rdata` changes only in a `cpu_done` cycle, and only for a read. A write leaves it unchanged.
- R9: `cpu_busy` is high from the cycle after an accepted start until the done cycle. A `cpu_start` seen while busy is dropped and starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_start | input | 1 | One-cycle access strobe, taken only when idle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Base address in bus-width units |
| cpu_wdata | input | WORD_W | Word to write |
| big_endian | input | 1 | Slice order for this access |
| fixed_mode | input | 1 | 1 = timed beats, completion ignored |
| cpu_busy | output | 1 | Access in progress |
| cpu_done | output | 1 | One-cycle end-of-access pulse |
| cpu_rdata | output | WORD_W | CPU data register, loaded on read completion |
| mem_req | output | 1 | Beat request |
| mem_rw | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | ADDR_W | Beat address |
| mem_wdata | output | BEAT_W | Beat write data |
| mem_rdata | input | BEAT_W | Beat read data |
| mem_complete | input | 1 | Memory completion handshake |

## Verification
Assertions check the handshake rules on every cycle:
- the request is held and dropped in step with completion;
- the beat fields stay stable during a request;
- request pulses have the fixed length in timed mode;
- done is a single pulse;
- the CPU data register moves only on done;
- the request only occurs while busy.

Only the bench scenarios can show whether the data is right. They cover the beat count and addresses, slice placement under both orders, and the assembled read word. They also show that a start strobe issued mid-access leaves no trace.

// File: rtl/membus_pkg.sv
package membus_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_DROP = 2'd2
  } seq_state_e;

  // Word slice used by beat number idx for an N-beat word.
  function automatic int unsigned lane_sel(input int unsigned idx,
                                           input int unsigned n,
                                           input logic big);
    return big ? (n - 1 - idx) : idx;
  endfunction

endpackage

// File: rtl/mb_seq.sv
module mb_seq #(
  parameter int unsigned NBEAT       = 4,
  parameter int unsigned WAIT_CYCLES = 2,
  localparam int unsigned IDX_W  = (NBEAT > 1) ? $clog2(NBEAT) : 1,
  localparam int unsigned WAIT_W = $clog2(WAIT_CYCLES + 1),
  localparam int unsigned RUN_W  = WAIT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             fixed_i,
  input  logic             complete_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             req_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             capture_o,
  output logic             finish_o,
  output logic             done_o
);
  import membus_pkg::*;

  seq_state_e          state_q;
  logic [IDX_W-1:0]    idx_q;
  logic [WAIT_W-1:0]   wait_q;
  logic                fixed_q;
  logic                done_q;
  logic [RUN_W-1:0]    run_q;

  // Named internal events
  logic hs_mode, beat_end, release_ok, last_beat;

  assign hs_mode    = !fixed_q;
  assign last_beat  = (idx_q == IDX_W'(NBEAT - 1));
  assign beat_end   = (state_q == SEQ_REQ) &&
                      (fixed_q ? (wait_q == WAIT_W'(WAIT_CYCLES - 1)) : complete_i);
  assign release_ok = (state_q == SEQ_DROP) && (fixed_q || !complete_i);

  assign accept_o  = (state_q == SEQ_IDLE) && start_i;
  assign busy_o    = (state_q != SEQ_IDLE);
  assign req_o     = (state_q == SEQ_REQ);
  assign idx_o     = idx_q;
  assign capture_o = beat_end;
  assign finish_o  = release_ok && last_beat;
  assign done_o    = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      wait_q  <= '0;
      fixed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish_o;
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            state_q <= SEQ_REQ;
            idx_q   <= '0;
            wait_q  <= '0;
            fixed_q <= fixed_i;
          end
        end
        SEQ_REQ: begin
          wait_q <= wait_q + 1'b1;
          if (beat_end) begin
            state_q <= SEQ_DROP;
            wait_q  <= '0;
          end
        end
        SEQ_DROP: begin
          if (release_ok) begin
            if (last_beat) state_q <= SEQ_IDLE;
            else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= SEQ_REQ;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // Request run length, used by the timed-mode check
  always_ff @(posedge clk) begin
    if (!rst_n)     run_q <= '0;
    else if (req_o) run_q <= run_q + 1'b1;
    else            run_q <= '0;
  end

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && hs_mode && !complete_i |=> req_o);
  assert_req_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && hs_mode && complete_i |=> !req_o);
  assert_fixed_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_q && $fell(req_o) |-> run_q == RUN_W'(WAIT_CYCLES));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/mb_lanes.sv
module mb_lanes #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned BEAT_W = 8,
  localparam int unsigned NBEAT = WORD_W / BEAT_W,
  localparam int unsigned IDX_W = (NBEAT > 1) ? $clog2(NBEAT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              big_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              capture_i,
  input  logic              load_i,
  input  logic              done_i,
  input  logic [BEAT_W-1:0] mem_rdata_i,
  output logic [BEAT_W-1:0] mem_wdata_o,
  output logic [WORD_W-1:0] cpu_rdata_o
);
  import membus_pkg::*;

  logic [WORD_W-1:0] asm_q;
  logic [WORD_W-1:0] rdata_q;
  int unsigned       lane;

  assign lane        = lane_sel(32'(idx_i), NBEAT, big_i);
  assign mem_wdata_o = wdata_i[lane*BEAT_W +: BEAT_W];
  assign cpu_rdata_o = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asm_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (capture_i) asm_q[lane*BEAT_W +: BEAT_W] <= mem_rdata_i;
      if (load_i)    rdata_q <= asm_q;
    end
  end

  assert_rdata_only_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cpu_rdata_o) |-> done_i);

endmodule

// File: rtl/membus_adapter.sv
module membus_adapter #(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned BEAT_W      = 8,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned WAIT_CYCLES = 2,
  localparam int unsigned NBEAT = WORD_W / BEAT_W,
  localparam int unsigned IDX_W = (NBEAT > 1) ? $clog2(NBEAT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_start,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  input  logic              big_endian,
  input  logic              fixed_mode,
  output logic              cpu_busy,
  output logic              cpu_done,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_rw,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BEAT_W-1:0] mem_wdata,
  input  logic [BEAT_W-1:0] mem_rdata,
  input  logic              mem_complete
);

  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic              wr_q, big_q;

  logic             accept, capture, finish, load_rd;
  logic [IDX_W-1:0] idx;

  mb_seq #(.NBEAT(NBEAT), .WAIT_CYCLES(WAIT_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(cpu_start), .fixed_i(fixed_mode),
    .complete_i(mem_complete), .accept_o(accept), .busy_o(cpu_busy),
    .req_o(mem_req), .idx_o(idx), .capture_o(capture), .finish_o(finish),
    .done_o(cpu_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      big_q   <= 1'b0;
    end else if (accept) begin
      addr_q  <= cpu_addr;
      wdata_q <= cpu_wdata;
      wr_q    <= cpu_wr;
      big_q   <= big_endian;
    end
  end

  assign load_rd  = finish && !wr_q;
  assign mem_rw   = wr_q;
  assign mem_addr = addr_q + ADDR_W'(idx);

  mb_lanes #(.WORD_W(WORD_W), .BEAT_W(BEAT_W)) u_lanes (
    .clk(clk), .rst_n(rst_n), .wdata_i(wdata_q), .big_i(big_q), .idx_i(idx),
    .capture_i(capture), .load_i(load_rd), .done_i(cpu_done),
    .mem_rdata_i(mem_rdata), .mem_wdata_o(mem_wdata), .cpu_rdata_o(cpu_rdata)
  );

  assert_beat_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req ||
      ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_rw)));
  assert_req_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cpu_busy);
  assert_idle_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !cpu_busy && !mem_req);

endmodule

// File: tb/membus_adapter_bench.sv
module membus_adapter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 32, BEAT_W = 8, ADDR_W = 12, WAIT_CYCLES = 3;
  localparam int NB = WORD_W / BEAT_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_start = 0, cpu_wr = 0, big_endian = 0, fixed_mode = 0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [WORD_W-1:0] cpu_wdata = '0;
  logic cpu_busy, cpu_done, mem_req, mem_rw;
  logic [WORD_W-1:0] cpu_rdata;
  logic [ADDR_W-1:0] mem_addr;
  logic [BEAT_W-1:0] mem_wdata, mem_rdata;
  logic mem_complete;

  always #(CLK_PERIOD/2) clk = ~clk;

  membus_adapter #(.WORD_W(WORD_W), .BEAT_W(BEAT_W), .ADDR_W(ADDR_W),
                   .WAIT_CYCLES(WAIT_CYCLES)) u_membus_adapter (
    .clk(clk), .rst_n(rst_n), .cpu_start(cpu_start), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .big_endian(big_endian),
    .fixed_mode(fixed_mode), .cpu_busy(cpu_busy), .cpu_done(cpu_done),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_rw(mem_rw),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_complete(mem_complete)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model
  logic [7:0] mem_arr [256];
  int  lat_cfg = 0;
  bit  fixed_drv = 0;
  int  lat_cnt = 0;
  logic cpl_q = 1'b0;
  assign mem_complete = cpl_q;
  assign mem_rdata = mem_arr[mem_addr[7:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem_arr[i] <= 8'(i * 7 + 3);
      cpl_q <= 1'b0;
      lat_cnt <= 0;
    end else if (fixed_drv) begin
      cpl_q <= 1'b1;
      if (mem_req && mem_rw) mem_arr[mem_addr[7:0]] <= mem_wdata;
    end else if (mem_req && !cpl_q) begin
      if (lat_cnt >= lat_cfg) begin
        cpl_q <= 1'b1;
        lat_cnt <= 0;
        if (mem_rw) mem_arr[mem_addr[7:0]] <= mem_wdata;
      end else lat_cnt <= lat_cnt + 1;
    end else if (!mem_req && cpl_q) cpl_q <= 1'b0;
  end

  // Scoreboard queues
  typedef struct { logic [ADDR_W-1:0] a; logic [7:0] d; bit wr; } beat_t;
  typedef struct { bit wr; logic [WORD_W-1:0] w; } res_t;
  beat_t bq[$];
  res_t  rq[$];
  int    dones = 0;
  logic [WORD_W-1:0] last_rd = '0;

  // Monitor
  initial begin
    beat_t cur;
    res_t  r;
    bit prev_req = 0, prev_cpl = 0, prev_done = 0;
    int run = 0;
    cur = '{a: '0, d: '0, wr: 0};
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (mem_req && !prev_req) begin
          if (bq.size() == 0) chk(0, "R9 unexpected beat", 32'(mem_addr), 32'hFFFFFFFF);
          else begin
            cur = bq.pop_front();
            chk(mem_addr == cur.a, "R2 beat address", 32'(mem_addr), 32'(cur.a));
            chk(mem_rw == cur.wr, "R2 beat direction", 32'(mem_rw), 32'(cur.wr));
            if (cur.wr) chk(mem_wdata == cur.d, "R3,R4 beat data", 32'(mem_wdata), 32'(cur.d));
          end
        end else if (mem_req) begin
          chk(mem_addr == cur.a && (!cur.wr || mem_wdata == cur.d), "R6 beat stable",
              32'(mem_addr), 32'(cur.a));
        end
        if (!fixed_drv && prev_req && prev_cpl)
          chk(!mem_req, "R5 request drop", 32'(mem_req), 32'd0);
        if (!fixed_drv && mem_req && !prev_req)
          chk(!prev_cpl, "R5 rise after completion low", 32'(prev_cpl), 32'd0);
        if (mem_req) run++;
        else begin
          if (prev_req && fixed_drv) chk(run == WAIT_CYCLES, "R7 fixed beat length", 32'(run), 32'(WAIT_CYCLES));
          run = 0;
        end
        if (cpu_done) begin
          dones++;
          chk(!prev_done, "R8 done single pulse", 32'(prev_done), 32'd0);
          if (rq.size() == 0) chk(0, "R9 unexpected done", 32'd1, 32'd0);
          else begin
            r = rq.pop_front();
            if (r.wr) chk(cpu_rdata == last_rd, "R8 rdata kept on write", cpu_rdata, last_rd);
            else begin
              chk(cpu_rdata == r.w, "R8 assembled read word", cpu_rdata, r.w);
              last_rd = r.w;
            end
          end
        end
        prev_req = mem_req; prev_cpl = mem_complete; prev_done = cpu_done;
      end
    end
  end

  // Driver: pushes expectations, then runs the access
  task automatic access(input logic [ADDR_W-1:0] a, input logic [31:0] w, input bit wr,
                        input bit big, input bit fx, input int lat, input bit poke);
    res_t r;
    logic [31:0] exp_w = '0;
    for (int k = 0; k < NB; k++) begin
      beat_t b;
      int ln = big ? (NB - 1 - k) : k;
      b.a = a + ADDR_W'(k);
      b.wr = wr;
      b.d = w[ln*8 +: 8];
      bq.push_back(b);
      exp_w[ln*8 +: 8] = mem_arr[8'(b.a)];
    end
    r.wr = wr; r.w = exp_w;
    rq.push_back(r);
    @(negedge clk);
    lat_cfg = lat; fixed_drv = fx;
    cpu_addr = a; cpu_wdata = w; cpu_wr = wr; big_endian = big; fixed_mode = fx;
    cpu_start = 1;
    @(negedge clk);
    cpu_start = 0;
    for (int c = 0; c < 400 && !cpu_done; c++) begin
      if (poke && c == 4) begin
        chk(cpu_busy, "R9 busy during access", 32'(cpu_busy), 32'd1);
        cpu_addr = 12'h0C0; cpu_wr = 1; cpu_start = 1;
      end else cpu_start = 0;
      @(negedge clk);
    end
    cpu_start = 0;
    if (fx) begin
      fixed_drv = 0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!mem_req && !cpu_busy && !cpu_done && cpu_rdata == '0, "R1 reset state",
        {cpu_rdata[28:0], mem_req, cpu_busy, cpu_done}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk(!mem_req && !cpu_busy && cpu_rdata == '0, "R1 after reset", cpu_rdata, 32'd0);

    access(12'h010, 32'd0, 0, 0, 0, 0, 0);             // R2 R3 read little
    access(12'h040, 32'h11223344, 1, 0, 0, 2, 0);      // R3 write little
    @(negedge clk);
    chk(mem_arr[8'h40] == 8'h44, "R3 low byte at base", 32'(mem_arr[8'h40]), 32'h44);
    chk(mem_arr[8'h43] == 8'h11, "R3 high byte at top", 32'(mem_arr[8'h43]), 32'h11);
    access(12'h050, 32'h11223344, 1, 1, 0, 1, 0);      // R4 write big
    @(negedge clk);
    chk(mem_arr[8'h50] == 8'h11, "R4 high byte at base", 32'(mem_arr[8'h50]), 32'h11);
    access(12'h050, 32'd0, 0, 1, 0, 3, 0);             // R4 read big
    chk(cpu_rdata == 32'h11223344, "R4 big read back", cpu_rdata, 32'h11223344);
    access(12'h050, 32'd0, 0, 0, 0, 0, 0);             // R3/R4 cross order
    chk(cpu_rdata == 32'h44332211, "R4 little view of big word", cpu_rdata, 32'h44332211);
    access(12'h060, 32'hA5A55A5A, 1, 0, 0, 3, 1);      // R9 start while busy
    repeat (10) @(negedge clk);
    chk(bq.size() == 0 && !mem_req, "R9 dropped start left no beats", 32'(bq.size()), 32'd0);
    chk(dones == 6, "R9 done count", 32'(dones), 32'd6);
    access(12'h020, 32'd0, 0, 0, 1, 0, 0);             // R7 fixed read
    access(12'h070, 32'hCAFEF00D, 1, 1, 1, 0, 0);      // R7 fixed write big
    @(negedge clk);
    chk(mem_arr[8'h70] == 8'hCA, "R7 fixed write placed", 32'(mem_arr[8'h70]), 32'hCA);
    access(12'h070, 32'd0, 0, 1, 0, 1, 0);
    chk(cpu_rdata == 32'hCAFEF00D, "R7 fixed data read back", cpu_rdata, 32'hCAFEF00D);
    repeat (5) @(negedge clk);
    chk(rq.size() == 0 && bq.size() == 0, "R2 all beats and results seen",
        32'(rq.size() + bq.size()), 32'd0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule